// File: doc/BRIEF.md
# Serial Systematic Cyclic Encoder, Length 7

This block turns a 4-bit message, presented one bit per cycle, into a 7-bit codeword of the cyclic code whose generator is g(X) = X^3 + X + 1. The codeword is systematic: the message bits appear unchanged, and three parity bits are added. The parity is the remainder of X^3·u(X) divided by g(X). A three-stage division register forms this remainder while the message streams through.

A controller walks through three named states. `ST_IDLE` waits for a start pulse. The transition `idle->load`, taken on start, clears the division register. In `ST_LOAD`, each message bit marked valid passes to the output one cycle later and is also folded into the division register through the closed feedback gate. After the fourth bit, the transition `load->flush` opens the gate. In `ST_FLUSH`, the register is shifted out as parity, with zeros entering behind it. After the third parity bit, the transition `flush->idle` returns the controller to idle and raises the done strobe.

The message is fed highest degree first (u3, u2, u1, u0). The codeword therefore leaves highest degree first as v6..v0: the four message bits, then the parity b2, b1, b0, which fill the low-degree positions of v(X).

Top module: `cyc_serial_enc`

## Requirements
- R1: While reset is held, and on the first sampled cycle after it, `dout_vld_o`, `dout_o` and `done_o` are all 0.
- R2: In `ST_IDLE`, a `din_vld_i` without a start produces no output beat. A start pulse in `ST_IDLE` clears the division register and enters the message phase.
- R3: In the message phase, each bit with `din_vld_i`=1 appears on `dout_o` with `dout_vld_o`=1 exactly one cycle later. The bits keep their order, u3 first and u0 last, where u_i is the coefficient of X^i and bit i of the message value.
- R4: The three bits that follow the message equal b2, b1, b0, where b(X) = X^3·u(X) mod (X^3 + X + 1). As examples, message value 1 gives v0..v6 = 1101000, value 8 gives 1010001, value 15 gives all ones, and value 0 gives all zeros.
- R5: The three parity beats come on consecutive cycles directly after the last message beat. `din_vld_i` and `din_i` during those cycles have no effect on the output.
- R6: `done_o` is high for exactly one cycle per codeword, in the same cycle as the seventh beat. The cycle after that carries no beat.
- R7: A start pulse in the message or parity phase is ignored. The codeword in progress completes unchanged.
- R8: Cycles with `din_vld_i`=0 in the message phase stall the encoder without changing the codeword.
- R9: Back-to-back codewords are independent. The parity of each depends only on its own message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a codeword (accepted in idle only) |
| din_i | input | 1 | Serial message bit |
| din_vld_i | input | 1 | Message bit qualifier |
| dout_o | output | 1 | Serial codeword bit, highest degree first |
| dout_vld_o | output | 1 | Codeword bit qualifier |
| done_o | output | 1 | Marks the final codeword bit |

## Verification
The bench builds the block with its default parameters: four message bits, three parity stages and generator 1011. This makes the whole message space of sixteen values small enough to sweep. Each message is compared against a remainder the bench computes by long division. The sweep runs once with valid held high, and once with idle gaps and stray start and data pulses while the encoder is busy, so the stall and ignore rules meet every message value. Back-to-back words and the four listed example codewords are checked as well.

// File: rtl/cyc_enc_pkg.sv
package cyc_enc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_FLUSH = 2'd2
    } enc_state_t;

    function automatic int unsigned cnt_width(input int unsigned a, input int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m <= 1) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/cyc_enc_ctrl.sv
module cyc_enc_ctrl
    import cyc_enc_pkg::*;
#(
    parameter int unsigned MSG_K = 4,
    parameter int unsigned PAR_R = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       din_vld_i,
    output logic       clr_o,
    output logic       step_o,
    output logic       gate_o,
    output logic       unload_o,
    output logic       last_o,
    output enc_state_t state_o
);
    localparam int unsigned CNT_W = cnt_width(MSG_K, PAR_R);
    localparam logic [CNT_W-1:0] K_LAST = CNT_W'(MSG_K - 1);
    localparam logic [CNT_W-1:0] R_LAST = CNT_W'(PAR_R - 1);

    enc_state_t        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // state register and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state and control outputs
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        clr_o    = 1'b0;
        step_o   = 1'b0;
        gate_o   = 1'b0;
        unload_o = 1'b0;
        last_o   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin          // idle->load
                    clr_o = 1'b1;
                    cnt_d = '0;
                    st_d  = ST_LOAD;
                end
            end
            ST_LOAD: begin
                gate_o = 1'b1;
                if (din_vld_i) begin
                    step_o = 1'b1;
                    if (cnt_q == K_LAST) begin   // load->flush
                        cnt_d = '0;
                        st_d  = ST_FLUSH;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_FLUSH: begin
                step_o   = 1'b1;
                unload_o = 1'b1;
                if (cnt_q == R_LAST) begin       // flush->idle
                    last_o = 1'b1;
                    cnt_d  = '0;
                    st_d   = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign state_o = st_q;

endmodule

// File: rtl/cyc_enc_divider.sv
module cyc_enc_divider #(
    parameter int unsigned      PAR_R    = 3,
    parameter logic [PAR_R:0]   GEN_POLY = 4'b1011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic             gate_i,
    input  logic             bit_i,
    output logic             msb_o
);
    logic [PAR_R-1:0] rem_q, rem_d;
    logic             fb;

    // feedback only while the gate is closed (message entry)
    assign fb = gate_i & (bit_i ^ rem_q[PAR_R-1]);

    assign rem_d[0] = GEN_POLY[0] & fb;
    for (genvar i = 1; i < PAR_R; i++) begin : g_stage
        if (GEN_POLY[i]) begin : g_tap
            assign rem_d[i] = rem_q[i-1] ^ fb;
        end else begin : g_notap
            assign rem_d[i] = rem_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rem_q <= '0;
        else if (clr_i)  rem_q <= '0;
        else if (step_i) rem_q <= rem_d;
    end

    assign msb_o = rem_q[PAR_R-1];

endmodule

// File: rtl/cyc_serial_enc.sv
module cyc_serial_enc
    import cyc_enc_pkg::*;
#(
    parameter int unsigned          MSG_K    = 4,
    parameter int unsigned          PAR_R    = 3,
    parameter logic [PAR_R:0]       GEN_POLY = 4'b1011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic din_i,
    input  logic din_vld_i,
    output logic dout_o,
    output logic dout_vld_o,
    output logic done_o
);
    logic       clr, step, gate, unload, last, par_bit;
    enc_state_t fsm_st;

    cyc_enc_ctrl #(.MSG_K(MSG_K), .PAR_R(PAR_R)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .din_vld_i (din_vld_i),
        .clr_o     (clr),
        .step_o    (step),
        .gate_o    (gate),
        .unload_o  (unload),
        .last_o    (last),
        .state_o   (fsm_st)
    );

    cyc_enc_divider #(.PAR_R(PAR_R), .GEN_POLY(GEN_POLY)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .step_i (step),
        .gate_i (gate),
        .bit_i  (din_i),
        .msb_o  (par_bit)
    );

    // registered output stage: message echo or parity unload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_o     <= 1'b0;
            dout_vld_o <= 1'b0;
            done_o     <= 1'b0;
        end else begin
            dout_vld_o <= step;
            dout_o     <= step & (unload ? par_bit : din_i);
            done_o     <= last;
        end
    end

endmodule

// File: rtl/cyc_serial_enc_chk.sv
module cyc_serial_enc_chk
    import cyc_enc_pkg::*;
#(
    parameter int unsigned MSG_K = 4,
    parameter int unsigned PAR_R = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       dout_vld_o,
    input logic       done_o,
    input enc_state_t fsm_st
);
    localparam int unsigned N_BEATS = MSG_K + PAR_R;
    int unsigned beats_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         beats_q <= 0;
        else if (done_o)    beats_q <= 0;
        else if (dout_vld_o) beats_q <= beats_q + 1;
    end

    assert_done_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (dout_vld_o && beats_q == N_BEATS - 1));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !dout_vld_o));

    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_st == ST_IDLE) |=> !dout_vld_o);

    assert_start_enters_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_st == ST_IDLE && start_i) |=> (fsm_st == ST_LOAD));

    assert_flush_streams_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_st == ST_FLUSH) |=> dout_vld_o);

    assert_load_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_st == ST_LOAD) |=> (fsm_st != ST_IDLE));

endmodule

bind cyc_serial_enc cyc_serial_enc_chk #(.MSG_K(MSG_K), .PAR_R(PAR_R)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dout_vld_o (dout_vld_o),
    .done_o     (done_o),
    .fsm_st     (fsm_st)
);

// File: tb/tb_cyc_serial_enc.sv
module tb_cyc_serial_enc;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, din_i = 1'b0, din_vld_i = 1'b0;
    logic dout_o, dout_vld_o, done_o;

    int checks = 0, failures = 0;
    logic cap [0:4095];
    int ncap = 0, done_at = -1, done_cnt = 0;

    always #2.5 clk = ~clk;

    cyc_serial_enc dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .din_i(din_i),
        .din_vld_i(din_vld_i), .dout_o(dout_o), .dout_vld_o(dout_vld_o), .done_o(done_o)
    );

    // collector, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (dout_vld_o) begin
                cap[ncap] = dout_o;
                ncap = ncap + 1;
            end
            if (done_o) begin
                done_at = ncap;
                done_cnt = done_cnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_word(input logic [3:0] m);
        logic [6:0] x;
        x = {m, 3'b000};
        for (int d = 6; d >= 3; d--)
            if (x[d]) x = x ^ (7'b0001011 << (d - 3));
        return {m, x[2:0]};
    endfunction

    // encode one word; gaps inserts stalls, noise pokes start/data while busy
    task automatic run_word(input logic [3:0] m, input bit gaps, input bit noise,
                            output logic [6:0] got);
        int base, dc0, wait_n;
        logic [6:0] exp;
        base = ncap;
        dc0  = done_cnt;
        exp  = ref_word(m);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 3; i >= 0; i--) begin
            if (gaps) begin
                din_vld_i = 1'b0; din_i = ~m[i];
                if (noise) start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
            end
            din_vld_i = 1'b1; din_i = m[i];
            @(negedge clk);
        end
        din_vld_i = noise; din_i = noise; start_i = noise;
        wait_n = 0;
        while (done_cnt == dc0 && wait_n < 20) begin
            @(negedge clk);
            wait_n++;
        end
        din_vld_i = 1'b0; din_i = 1'b0; start_i = 1'b0;
        for (int j = 0; j < 7; j++) got[6-j] = cap[base + j];
        check(ncap - base == 7, "R5 beat count", ncap - base, 7);
        check(got[6:3] == m, "R3 message echo", got[6:3], m);
        check(got == exp, gaps ? "R8 R4 codeword" : "R4 codeword", got, exp);
        check(done_cnt == dc0 + 1 && done_at == base + 7, "R6 done strobe", done_at - base, 7);
        if (noise) check(got == exp, "R7 busy start ignored", got, exp);
        @(negedge clk);
        check(ncap == base + 7, "R6 no beat after done", ncap - base, 7);
    endtask

    initial begin
        logic [6:0] w;
        int n0;
        #1;
        check(dout_vld_o == 0 && dout_o == 0 && done_o == 0, "R1 in reset", dout_vld_o, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dout_vld_o == 0 && done_o == 0, "R1 after reset", dout_vld_o, 0);
        // R2: data in idle ignored
        n0 = ncap;
        din_vld_i = 1'b1; din_i = 1'b1;
        repeat (3) @(negedge clk);
        din_vld_i = 1'b0; din_i = 1'b0;
        @(negedge clk);
        check(ncap == n0, "R2 idle data ignored", ncap - n0, 0);
        // R4 listed examples (v0..v6 reversed into w[0..6])
        run_word(4'd1, 0, 0, w);  check(w == 7'b0001011, "R4 value1", w, 7'b0001011);
        run_word(4'd8, 0, 0, w);  check(w == 7'b1000101, "R4 value8", w, 7'b1000101);
        run_word(4'd15, 0, 0, w); check(w == 7'h7F, "R4 all ones", w, 7'h7F);
        run_word(4'd0, 0, 0, w);  check(w == 7'h00, "R4 all zeros", w, 7'h00);
        // R9: back-to-back, no idle cycle beyond the required one
        for (int m = 0; m < 16; m++) run_word(4'(m), 0, 0, w);
        // R8 and R7 sweeps
        for (int m = 0; m < 16; m++) run_word(4'(m), 1, 0, w);
        for (int m = 0; m < 16; m++) run_word(4'(15 - m), 1, 1, w);
        run_word(4'd15, 0, 0, w);
        run_word(4'd2, 0, 0, w);
        check(w == ref_word(4'd2), "R9 independent word", w, ref_word(4'd2));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule